// File: doc/BRIEF.md
# Successive-Approximation Scan Controller

This block is the digital side of a 12-bit successive-approximation converter. It drives an external sample stage, DAC and comparator through a narrow bit-trial interface: it raises `sample_en` for a programmable number of cycles, presents a trial code on `trial_code`, and reads one comparator bit back on `cmp_hi`. Twelve such trials, most significant bit first, produce one result.

A single start event converts a contiguous run of analog inputs, from `scan_first` up to `scan_last`, one after another. The start event comes from one of three sources, chosen by `trig_sel`: a software start level, a timer underflow pulse, or an active-low external pin. In one-shot mode the run happens once. In repeat mode the run restarts while the software start level stays high.

Every finished conversion does four things. It writes the 12-bit result into a 16-bit output. It sets that input's done flag. It may raise an overwrite flag. It may pulse a DMA request. The interrupt output combines the flags with their enables.

Two state machines control the block. The sequencer has three states. SEQ_IDLE goes to SEQ_LAUNCH on a start event. SEQ_LAUNCH goes to SEQ_WAIT after one cycle. SEQ_WAIT, when a conversion ends, goes back to SEQ_LAUNCH for the next input or the restarted run, or goes to SEQ_IDLE at the end of a run or on a stop request.

The bit engine has four states. ENG_IDLE goes to ENG_SAMPLE on a launch. ENG_SAMPLE goes to ENG_TRIAL when its counter expires. ENG_TRIAL goes to ENG_DONE after the bit-0 trial. ENG_DONE returns to ENG_IDLE after one cycle.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `sample_en`, `trial_code`, `data_out`, `done_flags`, `ovf_flag`, `irq` and `dma_req` are all zero.
- R2: The `trig_sel` codes select the start event. Code 0 starts on a 0-to-1 change of `sw_start`. Code 1 starts on a high `tmr_uf` cycle. Code 2 starts on a 1-to-0 change of `ext_trig_n`. Code 3 never starts. A source that is not selected has no effect.
- R3: Each conversion has three phases. First, `sample_en` is high for max(`smp_cyc`,1) cycles. Then come 12 trial cycles. In each trial cycle, `trial_code` equals the bits already kept OR the current trial bit, starting at bit 11. A bit is kept when `cmp_hi` is 1. Outside the trial cycles, `trial_code` is 0.
- R4: At the end of each conversion, `data_out` takes the 12-bit result zero-extended to 16 bits. It holds that value until the next conversion ends.
- R5: A conversion takes max(`smp_cyc`,1)+14 cycles from the start event or from the previous conversion's end. Inputs are converted in increasing order from `scan_first`, modulo 8. `ain_sel` shows the current input. `busy` stays high from the cycle after the start event until the last conversion ends.
- R6: With `cont_mode`=0, the run stops after the conversion of `scan_last`.
- R7: With `cont_mode`=1, the run restarts at `scan_first` after `scan_last` if `sw_start` is high. If `sw_start` is low when any conversion ends, the run stops after that conversion.
- R8: Start events that arrive while `busy` is high are ignored. They are not queued.
- R9: Bit i of `done_flags` is set when a conversion of input i ends. Each bit is cleared by writing 1 to the matching `flag_clr` bit. A set in the same cycle wins over the clear.
- R10: `ovf_flag` is set when a result is stored while the previous result is still unread, unless `data_rd` is high in that same cycle. A `data_rd` pulse marks the result as read. `ovf_clr` clears `ovf_flag`, and a set in the same cycle wins over the clear.
- R11: `irq` is high exactly when some `done_flags` bit is set with its `irq_en` bit high, or when `ovf_flag` and `ovf_ie` are both high.
- R12: `dma_req` pulses high for one cycle, right after a conversion of input i ends, when `dma_en[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_sel | input | 2 | Start source: 0 software, 1 timer, 2 external, 3 none |
| sw_start | input | 1 | Software start level; also keeps repeat mode running |
| tmr_uf | input | 1 | Timer underflow pulse |
| ext_trig_n | input | 1 | External start pin, active low |
| cont_mode | input | 1 | 1 = repeat mode, 0 = one-shot |
| scan_first | input | 3 | First input of a run |
| scan_last | input | 3 | Last input of a run |
| smp_cyc | input | 4 | Sample cycles before the first trial (0 acts as 1) |
| cmp_hi | input | 1 | Comparator: input is at or above the trial level |
| data_rd | input | 1 | Result read strobe |
| flag_clr | input | 8 | Write-1-to-clear strobes for the done flags |
| ovf_clr | input | 1 | Clear strobe for the overwrite flag |
| irq_en | input | 8 | Interrupt enables, one per input |
| ovf_ie | input | 1 | Overwrite interrupt enable |
| dma_en | input | 8 | DMA request enables, one per input |
| busy | output | 1 | A run is in progress |
| ain_sel | output | 3 | Input being converted |
| sample_en | output | 1 | Sample phase active |
| trial_code | output | 12 | Code presented to the DAC |
| data_out | output | 16 | Latest result, zero-extended |
| done_flags | output | 8 | Per-input completion flags |
| ovf_flag | output | 1 | Overwrite error flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
A reference model in the bench tracks the remaining cycles of the current conversion and predicts every output on every clock. A wrong sequencer or engine state therefore shows within one cycle, through a mismatch on `sample_en`, `trial_code`, `busy` or `ain_sel`. A wrong kept bit in the trial accumulator shows on the next trial code, and again on `data_out` when the conversion ends. An error in the flag bookkeeping shows on `done_flags`, `ovf_flag`, `irq` or `dma_req` in the cycle after the conversion ends.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SAMPLE,
        ENG_TRIAL,
        ENG_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LAUNCH,
        SEQ_WAIT
    } seq_state_t;

    localparam logic [1:0] TRIG_SOFT = 2'd0;
    localparam logic [1:0] TRIG_TMR  = 2'd1;
    localparam logic [1:0] TRIG_EXT  = 2'd2;

endpackage

// File: rtl/sar_trig_sel.sv
`timescale 1ns/1ps
module sar_trig_sel
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] trig_sel,
    input  logic       sw_start,
    input  logic       tmr_uf,
    input  logic       ext_trig_n,
    output logic       trig_evt
);
    logic sw_q;
    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q  <= 1'b0;
            ext_q <= 1'b1;
        end else begin
            sw_q  <= sw_start;
            ext_q <= ext_trig_n;
        end
    end

    always_comb begin
        unique case (trig_sel)
            TRIG_SOFT: trig_evt = sw_start & ~sw_q;
            TRIG_TMR:  trig_evt = tmr_uf;
            TRIG_EXT:  trig_evt = ~ext_trig_n & ext_q;
            default:   trig_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
module sar_bit_engine
    import sar_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int SMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SMP_W-1:0] smp_cyc,
    input  logic             cmp_hi,
    output logic             sample_en,
    output logic [RES_W-1:0] trial_code,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W);

    eng_state_t       st;
    logic [SMP_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ENG_IDLE;
            cnt <= '0;
            idx <= '0;
            acc <= '0;
        end else begin
            unique case (st)
                ENG_IDLE: if (go) begin
                    st  <= ENG_SAMPLE;
                    cnt <= (smp_cyc == '0) ? SMP_W'(1) : smp_cyc;
                    acc <= '0;
                end
                ENG_SAMPLE: if (cnt == SMP_W'(1)) begin
                    st  <= ENG_TRIAL;
                    idx <= IDX_W'(RES_W - 1);
                end else begin
                    cnt <= cnt - SMP_W'(1);
                end
                ENG_TRIAL: begin
                    if (cmp_hi) acc[idx] <= 1'b1;
                    if (idx == '0) st <= ENG_DONE;
                    else           idx <= idx - IDX_W'(1);
                end
                ENG_DONE: st <= ENG_IDLE;
                default:  st <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        sample_en  = (st == ENG_SAMPLE);
        done       = (st == ENG_DONE);
        result     = acc;
        trial_code = (st == ENG_TRIAL) ? (acc | (RES_W'(1) << idx)) : '0;
    end

    // R3: the first trial presents only the top bit
    p_first_trial_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_TRIAL && $past(st) == ENG_SAMPLE) |-> trial_code == (RES_W'(1) << (RES_W - 1)));

endmodule

// File: rtl/sar_flag_bank.sv
`timescale 1ns/1ps
module sar_flag_bank #(
    parameter int RES_W  = 12,
    parameter int N_IN   = 8,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    store,
    input  logic [$clog2(N_IN)-1:0] store_sel,
    input  logic [RES_W-1:0]        result,
    input  logic                    data_rd,
    input  logic [N_IN-1:0]         flag_clr,
    input  logic                    ovf_clr,
    input  logic [N_IN-1:0]         irq_en,
    input  logic                    ovf_ie,
    input  logic [N_IN-1:0]         dma_en,
    output logic [DATA_W-1:0]       data_out,
    output logic [N_IN-1:0]         done_flags,
    output logic                    ovf_flag,
    output logic                    irq,
    output logic                    dma_req
);
    localparam int PAD_W = DATA_W - RES_W;

    logic [RES_W-1:0] data_r;
    logic             unread;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_r     <= '0;
            done_flags <= '0;
            ovf_flag   <= 1'b0;
            unread     <= 1'b0;
            dma_req    <= 1'b0;
        end else begin
            done_flags <= (done_flags & ~flag_clr) | (store ? (N_IN'(1) << store_sel) : '0);
            if (store && unread && !data_rd) ovf_flag <= 1'b1;
            else if (ovf_clr)                ovf_flag <= 1'b0;
            if (store)        unread <= 1'b1;
            else if (data_rd) unread <= 1'b0;
            if (store) data_r <= result;
            dma_req <= store & dma_en[store_sel];
        end
    end

    assign data_out = {{PAD_W{1'b0}}, data_r};
    assign irq      = (|(done_flags & irq_en)) | (ovf_flag & ovf_ie);

    // R9: flags move only on a completion or a clear strobe
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!store && flag_clr == '0) |=> $stable(done_flags));

    // R10: overwrite is raised only by a store
    p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(store));

    // R12: request lasts one cycle
    p_dma_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

endmodule

// File: rtl/sar_scan_ctrl.sv
`timescale 1ns/1ps
module sar_scan_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int N_IN   = 8,
    parameter int DATA_W = 16,
    parameter int SMP_W  = 4,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trig_sel,
    input  logic              sw_start,
    input  logic              tmr_uf,
    input  logic              ext_trig_n,
    input  logic              cont_mode,
    input  logic [SEL_W-1:0]  scan_first,
    input  logic [SEL_W-1:0]  scan_last,
    input  logic [SMP_W-1:0]  smp_cyc,
    input  logic              cmp_hi,
    input  logic              data_rd,
    input  logic [N_IN-1:0]   flag_clr,
    input  logic              ovf_clr,
    input  logic [N_IN-1:0]   irq_en,
    input  logic              ovf_ie,
    input  logic [N_IN-1:0]   dma_en,
    output logic              busy,
    output logic [SEL_W-1:0]  ain_sel,
    output logic              sample_en,
    output logic [RES_W-1:0]  trial_code,
    output logic [DATA_W-1:0] data_out,
    output logic [N_IN-1:0]   done_flags,
    output logic              ovf_flag,
    output logic              irq,
    output logic              dma_req
);
    seq_state_t       st;
    logic [SEL_W-1:0] cur;
    logic             trig_evt;
    logic             go;
    logic             eng_done;
    logic             store;
    logic [RES_W-1:0] eng_result;

    sar_trig_sel u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_sel   (trig_sel),
        .sw_start   (sw_start),
        .tmr_uf     (tmr_uf),
        .ext_trig_n (ext_trig_n),
        .trig_evt   (trig_evt)
    );

    sar_bit_engine #(.RES_W(RES_W), .SMP_W(SMP_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .smp_cyc    (smp_cyc),
        .cmp_hi     (cmp_hi),
        .sample_en  (sample_en),
        .trial_code (trial_code),
        .done       (eng_done),
        .result     (eng_result)
    );

    sar_flag_bank #(.RES_W(RES_W), .N_IN(N_IN), .DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (store),
        .store_sel  (cur),
        .result     (eng_result),
        .data_rd    (data_rd),
        .flag_clr   (flag_clr),
        .ovf_clr    (ovf_clr),
        .irq_en     (irq_en),
        .ovf_ie     (ovf_ie),
        .dma_en     (dma_en),
        .data_out   (data_out),
        .done_flags (done_flags),
        .ovf_flag   (ovf_flag),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            cur <= '0;
        end else begin
            unique case (st)
                SEQ_IDLE: if (trig_evt) begin
                    st  <= SEQ_LAUNCH;
                    cur <= scan_first;
                end
                SEQ_LAUNCH: st <= SEQ_WAIT;
                SEQ_WAIT: if (eng_done) begin
                    if (cur == scan_last) begin
                        if (cont_mode && sw_start) begin
                            cur <= scan_first;
                            st  <= SEQ_LAUNCH;
                        end else begin
                            st <= SEQ_IDLE;
                        end
                    end else if (cont_mode && !sw_start) begin
                        st <= SEQ_IDLE;
                    end else begin
                        cur <= cur + SEL_W'(1);
                        st  <= SEQ_LAUNCH;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (st != SEQ_IDLE);
        go      = (st == SEQ_LAUNCH);
        store   = (st == SEQ_WAIT) && eng_done;
        ain_sel = cur;
    end

    // R5: sampling happens only inside a run
    p_sample_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy);

    // R8: while a conversion is in flight the input and busy hold
    p_hold_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_WAIT && !eng_done) |=> (busy && $stable(ain_sel)));

endmodule

// File: tb/sar_scan_ctrl_test.sv
`timescale 1ns/1ps
module sar_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  trig_sel = 2'd0;
    logic        sw_start = 1'b0;
    logic        tmr_uf = 1'b0;
    logic        ext_trig_n = 1'b1;
    logic        cont_mode = 1'b0;
    logic [2:0]  scan_first = 3'd0;
    logic [2:0]  scan_last = 3'd0;
    logic [3:0]  smp_cyc = 4'd1;
    logic        cmp_hi;
    logic        data_rd = 1'b0;
    logic [7:0]  flag_clr = 8'h00;
    logic        ovf_clr = 1'b0;
    logic [7:0]  irq_en = 8'h00;
    logic        ovf_ie = 1'b0;
    logic [7:0]  dma_en = 8'h00;
    logic        busy;
    logic [2:0]  ain_sel;
    logic        sample_en;
    logic [11:0] trial_code;
    logic [15:0] data_out;
    logic [7:0]  done_flags;
    logic        ovf_flag;
    logic        irq;
    logic        dma_req;

    logic [11:0] ain [8];

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 1'b0;

    // comparator / DAC stub
    assign cmp_hi = (trial_code <= ain[ain_sel]);

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .sw_start(sw_start),
        .tmr_uf(tmr_uf), .ext_trig_n(ext_trig_n), .cont_mode(cont_mode),
        .scan_first(scan_first), .scan_last(scan_last), .smp_cyc(smp_cyc),
        .cmp_hi(cmp_hi), .data_rd(data_rd), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .irq_en(irq_en), .ovf_ie(ovf_ie), .dma_en(dma_en), .busy(busy),
        .ain_sel(ain_sel), .sample_en(sample_en), .trial_code(trial_code),
        .data_out(data_out), .done_flags(done_flags), .ovf_flag(ovf_flag),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin
            tick(1);
            k++;
        end
        chk("R5 run ends", int'(busy), 0);
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // behavioural reference model
    bit          m_busy;
    int          m_cur, m_left, m_nc, m_n, m_sel;
    logic [7:0]  m_flags;
    bit          m_ovf, m_unread, m_dma, m_sw_q, m_ext_q, m_trig, m_store;
    int          m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_cur = 0; m_left = 0; m_nc = 1; m_flags = 8'h00;
            m_ovf = 0; m_unread = 0; m_dma = 0; m_data = 0;
            m_sw_q = 0; m_ext_q = 1;
        end else begin
            m_n = (smp_cyc == 0) ? 1 : int'(smp_cyc);
            m_trig = (trig_sel == 2'd0 && sw_start && !m_sw_q) ||
                     (trig_sel == 2'd1 && tmr_uf) ||
                     (trig_sel == 2'd2 && !ext_trig_n && m_ext_q);
            m_sw_q = sw_start;
            m_ext_q = ext_trig_n;
            m_store = 0;
            m_sel = m_cur;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) m_store = 1;
            end
            m_flags = (m_flags & ~flag_clr) | (m_store ? (8'h01 << m_sel) : 8'h00);
            if (m_store && m_unread && !data_rd) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (m_store) m_unread = 1;
            else if (data_rd) m_unread = 0;
            m_dma = m_store && dma_en[m_sel];
            if (m_store) m_data = int'(ain[m_sel]);
            if (m_store) begin
                if (m_sel == int'(scan_last)) begin
                    if (cont_mode && sw_start) begin
                        m_cur = int'(scan_first); m_left = m_n + 14; m_nc = m_n;
                    end else m_busy = 0;
                end else if (cont_mode && !sw_start) begin
                    m_busy = 0;
                end else begin
                    m_cur = (m_cur + 1) % 8; m_left = m_n + 14; m_nc = m_n;
                end
            end else if (!m_busy && m_trig) begin
                m_busy = 1; m_cur = int'(scan_first); m_left = m_n + 14; m_nc = m_n;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            int idx;
            int exp_tc;
            bit exp_smp;
            exp_smp = m_busy && m_left >= 14 && m_left <= m_nc + 13;
            exp_tc = 0;
            if (m_busy && m_left >= 2 && m_left <= 13) begin
                idx = m_left - 2;
                exp_tc = ((int'(ain[m_cur]) >> (idx + 1)) << (idx + 1)) | (1 << idx);
            end
            chk("R5 busy", int'(busy), int'(m_busy));
            if (m_busy) chk("R5 ain_sel", int'(ain_sel), m_cur);
            chk("R3 sample_en", int'(sample_en), int'(exp_smp));
            chk("R3 trial_code", int'(trial_code), exp_tc);
            chk("R4 data_out", int'(data_out), m_data);
            chk("R9 done_flags", int'(done_flags), int'(m_flags));
            chk("R10 ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk("R11 irq", int'(irq),
                int'((|(m_flags & irq_en)) || (m_ovf && ovf_ie)));
            chk("R12 dma_req", int'(dma_req), int'(m_dma));
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R5 watchdog: run still active, got 1 expected 0");
        finish_run();
    end

    initial begin
        ain[0] = 12'h000; ain[1] = 12'hFFF; ain[2] = 12'hA5C; ain[3] = 12'h123;
        ain[4] = 12'h800; ain[5] = 12'h7FF; ain[6] = 12'h001; ain[7] = 12'h5A5;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 data_out", int'(data_out), 0);
        chk("R1 done_flags", int'(done_flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);

        // one-shot software run over inputs 1..3, no reads -> overwrite
        trig_sel = 2'd0; cont_mode = 1'b0; scan_first = 3'd1; scan_last = 3'd3;
        smp_cyc = 4'd2; irq_en = 8'h0E; dma_en = 8'h04;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        wait_idle();
        chk("R6 flags after one-shot", int'(done_flags), 8'h0E);
        chk("R4 last result", int'(data_out), 16'h0123);
        chk("R10 overwrite seen", int'(ovf_flag), 1);
        tick(20);
        chk("R6 stays idle", int'(busy), 0);
        flag_clr = 8'h06; ovf_clr = 1'b1; tick(1); flag_clr = 8'h00; ovf_clr = 1'b0;
        tick(1);
        chk("R9 write-1 clear", int'(done_flags), 8'h08);

        // timer source; software edge must be ignored
        trig_sel = 2'd1; scan_first = 3'd4; scan_last = 3'd5; smp_cyc = 4'd0;
        data_rd = 1'b1; ovf_ie = 1'b1; dma_en = 8'h30;
        sw_start = 1'b1; tick(3); sw_start = 1'b0; tick(1);
        chk("R2 unselected source ignored", int'(busy), 0);
        tmr_uf = 1'b1; tick(1); tmr_uf = 1'b0;
        tick(5);
        tmr_uf = 1'b1; tick(1); tmr_uf = 1'b0;
        tick(40);
        chk("R8 busy retrigger dropped", int'(busy), 0);
        chk("R10 no overwrite with reads", int'(ovf_flag), 0);
        data_rd = 1'b0;

        // external falling edge, single input
        trig_sel = 2'd2; scan_first = 3'd7; scan_last = 3'd7; smp_cyc = 4'd5;
        ext_trig_n = 1'b0; tick(3); ext_trig_n = 1'b1;
        chk("R2 external start", int'(busy), 1);
        wait_idle();
        chk("R4 external result", int'(data_out), 16'h05A5);

        // code 3 never starts
        trig_sel = 2'd3;
        sw_start = 1'b1; tmr_uf = 1'b1; ext_trig_n = 1'b0; tick(2);
        sw_start = 1'b0; tmr_uf = 1'b0; ext_trig_n = 1'b1; tick(2);
        chk("R2 code 3 idle", int'(busy), 0);

        // repeat mode with wrap-around order 6,7,0
        trig_sel = 2'd0; cont_mode = 1'b1; scan_first = 3'd6; scan_last = 3'd0;
        smp_cyc = 4'd1; dma_en = 8'hC1; irq_en = 8'hFF;
        sw_start = 1'b1; tick(1);
        tick(150);
        chk("R7 repeat still running", int'(busy), 1);
        sw_start = 1'b0;
        tick(16);
        chk("R7 stop after current", int'(busy), 0);
        cont_mode = 1'b0;
        tick(5);
        finish_run();
    end

endmodule